// File: doc/BRIEF.md
# Programmable Address Region Router

This block steers every request address to one of a small set of destinations. It holds a bank of programmable windows. Each window has a base value and a mask that are compared against the upper part of the address. Each window also has its own destination code, a flag that keeps its accesses out of the level-2 cache, and an optional cache-attribute override. When no enabled window covers an address, the request goes to a separately programmed default destination.

Software programs the windows and the default through a simple write port: an enable, a word offset and a data word. The decode itself is purely combinational from the request address to the routing outputs. A register write changes the routing from the cycle that follows the clock edge that captured it. When several windows cover the same address, the one with the lowest index decides the result.

Top module: `addr_region_router`

## Requirements
- R1: After reset every window is disabled and the default destination is 0, so any address yields route_tgt = 0 (memory), attr_ovr_vld = 0, attr_ovr_val = 0 and no_l2_alloc = 0.
- R2: Register offsets (wr_addr): default-destination register at 0x008 (bits 1:0). Window n has its base register at 0x090 + 0x10*n (base in bits 31:16) and its mask register at 0x098 + 0x10*n. In the mask register, bits 31:16 hold the mask, bits 1:0 the destination, bit 2 the L2 no-allocate flag, bit 4 the override enable and bits 7:5 the override value. A write to any other offset, or with wr_en low, changes no routing result.
- R3: A write captured at a rising edge changes the outputs only after that edge. The outputs follow req_addr combinationally within the same cycle.
- R4: Window n covers an address when (req_addr[31:16] & mask) equals (base & mask). A mask of all zeros therefore covers every address.
- R5: A window whose destination field is 0 is disabled and never covers an address.
- R6: route_tgt encoding: 0 = memory, 1 = reserved, 2 = I/O port 0, 3 = I/O port 1. The window destination codes map as follows: 1 (memory) gives 0, 2 gives 2, and 3 gives 3.
- R7: When more than one enabled window covers an address, the window with the lowest index supplies all outputs.
- R8: When no window covers an address, route_tgt equals the default-destination field unchanged (including the reserved value 1), and attr_ovr_vld, attr_ovr_val and no_l2_alloc are all 0.
- R9: attr_ovr_vld equals the override enable of the winning window. attr_ovr_val carries that window's override value when the enable is set and is 0 when it is clear.
- R10: no_l2_alloc equals the L2 no-allocate flag of the winning window.
- R11: Address bits 15:0 take no part in the decode. Base bits where the mask is 0 also take no part in the decode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register byte offset |
| wr_data | input | 32 | Register write data |
| req_addr | input | 32 | Request address to route |
| route_tgt | output | 2 | Selected destination code |
| attr_ovr_vld | output | 1 | Cache-attribute override is active |
| attr_ovr_val | output | 3 | Cache-attribute override value |
| no_l2_alloc | output | 1 | Request must not allocate in L2 |

## Verification
The route outputs depend only on req_addr and the stored registers. The bench therefore changes the address at a falling edge and samples one time unit later, within the same cycle. A register write is driven at a falling edge and takes effect at the next rising edge. The bench samples the routing once while the strobe is still high, before the capturing edge, and expects the old result. It samples again at the following falling edge and expects the new result. This pins down the one-cycle write latency.

// File: rtl/arr_pkg.sv
package arr_pkg;

   // field positions inside a window mask register
   localparam int DEST_LO  = 0;
   localparam int DEST_W   = 2;
   localparam int DROP_BIT = 2;
   localparam int OVEN_BIT = 4;
   localparam int OVAL_LO  = 5;
   localparam int OVAL_W   = 3;

   typedef enum logic [DEST_W-1:0] {
      WD_OFF = 2'd0,
      WD_MEM = 2'd1,
      WD_IO0 = 2'd2,
      WD_IO1 = 2'd3
   } win_dest_e;

   typedef enum logic [DEST_W-1:0] {
      RT_MEM  = 2'd0,
      RT_RSVD = 2'd1,
      RT_IO0  = 2'd2,
      RT_IO1  = 2'd3
   } route_e;

   typedef struct packed {
      win_dest_e         dest;
      logic              drop;
      logic              ovr_en;
      logic [OVAL_W-1:0] ovr_val;
   } win_attr_t;

   function automatic route_e dest_to_route(win_dest_e d);
      case (d)
         WD_MEM:  return RT_MEM;
         WD_IO0:  return RT_IO0;
         WD_IO1:  return RT_IO1;
         default: return RT_MEM;
      endcase
   endfunction

endpackage

// File: rtl/arr_regs.sv
module arr_regs
   import arr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int REG_AW     = 12,
   parameter int CMP_LO     = 16,
   parameter int NUM_WIN    = 4,
   parameter int CFG_OFS    = 'h008,
   parameter int WIN_OFS0   = 'h090,
   parameter int WIN_STRIDE = 'h010,
   parameter int MASK_DELTA = 'h008,
   localparam int CMP_W     = ADDR_W - CMP_LO
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [REG_AW-1:0]               wr_addr,
   input  logic [DATA_W-1:0]               wr_data,
   output logic [NUM_WIN-1:0][CMP_W-1:0]   base_q,
   output logic [NUM_WIN-1:0][CMP_W-1:0]   mask_q,
   output win_attr_t [NUM_WIN-1:0]         attr_q,
   output logic [DEST_W-1:0]               dflt_q
);

   localparam logic [REG_AW-1:0] CFG_A = REG_AW'(CFG_OFS);

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dflt_q <= '0;
      else if (wr_en && wr_addr == CFG_A)
         dflt_q <= wr_data[DEST_LO +: DEST_W];
   end

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      localparam logic [REG_AW-1:0] BASE_A = REG_AW'(WIN_OFS0 + g*WIN_STRIDE);
      localparam logic [REG_AW-1:0] MASK_A = REG_AW'(WIN_OFS0 + g*WIN_STRIDE + MASK_DELTA);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base_q[g] <= '0;
         else if (wr_en && wr_addr == BASE_A)
            base_q[g] <= wr_data[ADDR_W-1:CMP_LO];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[g] <= '0;
            attr_q[g] <= '0;
         end else if (wr_en && wr_addr == MASK_A) begin
            mask_q[g]         <= wr_data[ADDR_W-1:CMP_LO];
            attr_q[g].dest    <= win_dest_e'(wr_data[DEST_LO +: DEST_W]);
            attr_q[g].drop    <= wr_data[DROP_BIT];
            attr_q[g].ovr_en  <= wr_data[OVEN_BIT];
            attr_q[g].ovr_val <= wr_data[OVAL_LO +: OVAL_W];
         end
      end
   end

endmodule

// File: rtl/arr_match.sv
module arr_match
   import arr_pkg::*;
#(
   parameter int CMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] addr_hi,
   input  logic [CMP_W-1:0] base,
   input  logic [CMP_W-1:0] mask,
   input  win_dest_e        dest,
   output logic             hit
);

   logic field_eq;

   assign field_eq = ((addr_hi ^ base) & mask) == '0;
   assign hit      = field_eq && (dest != WD_OFF);

   // R5
   off_no_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dest == WD_OFF) |-> !hit);

   // R4
   zero_mask_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask == '0) && (dest != WD_OFF)) |-> hit);

endmodule

// File: rtl/arr_sel.sv
module arr_sel
   import arr_pkg::*;
#(
   parameter int NUM_WIN = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_WIN-1:0]     hit,
   input  win_attr_t [NUM_WIN-1:0] attr,
   input  logic [DEST_W-1:0]      dflt,
   output logic [NUM_WIN-1:0]     grant,
   output route_e                 tgt,
   output logic                   ovr_vld,
   output logic [OVAL_W-1:0]      ovr_val,
   output logic                   drop
);

   win_attr_t win;
   logic      found;

   // lowest index takes precedence
   always_comb begin
      grant = '0;
      found = 1'b0;
      win   = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (hit[i] && !found) begin
            found    = 1'b1;
            grant[i] = 1'b1;
            win      = attr[i];
         end
      end
   end

   always_comb begin
      if (found) begin
         tgt     = dest_to_route(win.dest);
         ovr_vld = win.ovr_en;
         ovr_val = win.ovr_en ? win.ovr_val : '0;
         drop    = win.drop;
      end else begin
         tgt     = route_e'(dflt);
         ovr_vld = 1'b0;
         ovr_val = '0;
         drop    = 1'b0;
      end
   end

   // R7
   one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R7
   low_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit[0] |-> grant[0]);

   // R7
   grant_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~hit) == '0);

endmodule

// File: rtl/addr_region_router.sv
module addr_region_router
   import arr_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int REG_AW     = 12,
   parameter int CMP_LO     = 16,
   parameter int NUM_WIN    = 4,
   parameter int CFG_OFS    = 'h008,
   parameter int WIN_OFS0   = 'h090,
   parameter int WIN_STRIDE = 'h010,
   parameter int MASK_DELTA = 'h008
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] req_addr,
   output logic [1:0]        route_tgt,
   output logic              attr_ovr_vld,
   output logic [2:0]        attr_ovr_val,
   output logic              no_l2_alloc
);

   localparam int CMP_W   = ADDR_W - CMP_LO;
   localparam int TOP_OFS = WIN_OFS0 + NUM_WIN*WIN_STRIDE;

   if (NUM_WIN < 1 || NUM_WIN > 8) begin : g_bad_win
      $error("NUM_WIN must lie in 1..8");
   end
   if (CMP_LO < 8 || CMP_LO >= ADDR_W) begin : g_bad_lo
      $error("CMP_LO must leave attribute bits 7:0 free and stay below ADDR_W");
   end
   if (DATA_W < ADDR_W) begin : g_bad_dw
      $error("DATA_W must be at least ADDR_W");
   end
   if (TOP_OFS > (1 << REG_AW) || MASK_DELTA >= WIN_STRIDE) begin : g_bad_map
      $error("register map does not fit REG_AW or windows overlap");
   end

   logic [NUM_WIN-1:0][CMP_W-1:0] base_q;
   logic [NUM_WIN-1:0][CMP_W-1:0] mask_q;
   win_attr_t [NUM_WIN-1:0]       attr_q;
   logic [DEST_W-1:0]             dflt_q;
   logic [NUM_WIN-1:0]            hit;
   logic [NUM_WIN-1:0]            grant;
   logic [CMP_W-1:0]              addr_hi;
   route_e                        tgt;
   logic                          unused_lo;

   assign addr_hi   = req_addr[ADDR_W-1:CMP_LO];
   assign unused_lo = ^{req_addr[CMP_LO-1:0], grant};

   arr_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_AW(REG_AW), .CMP_LO(CMP_LO),
      .NUM_WIN(NUM_WIN), .CFG_OFS(CFG_OFS), .WIN_OFS0(WIN_OFS0),
      .WIN_STRIDE(WIN_STRIDE), .MASK_DELTA(MASK_DELTA)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .base_q(base_q), .mask_q(mask_q),
      .attr_q(attr_q), .dflt_q(dflt_q)
   );

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_cmp
      arr_match #(.CMP_W(CMP_W)) u_match (
         .clk(clk), .rst_n(rst_n), .addr_hi(addr_hi), .base(base_q[g]),
         .mask(mask_q[g]), .dest(attr_q[g].dest), .hit(hit[g])
      );
   end

   arr_sel #(.NUM_WIN(NUM_WIN)) u_sel (
      .clk(clk), .rst_n(rst_n), .hit(hit), .attr(attr_q), .dflt(dflt_q),
      .grant(grant), .tgt(tgt), .ovr_vld(attr_ovr_vld),
      .ovr_val(attr_ovr_val), .drop(no_l2_alloc)
   );

   assign route_tgt = tgt;

   // R8
   dflt_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit == '0) |-> (!attr_ovr_vld && !no_l2_alloc && route_tgt == dflt_q));

   // R9
   ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !attr_ovr_vld |-> (attr_ovr_val == '0));

   // R3
   cfg_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_AW'(CFG_OFS)) |=>
         ((hit != '0) || route_tgt == $past(wr_data[1:0])));

   // R6
   win_never_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit != '0) |-> (route_tgt != 2'd1));

endmodule

// File: tb/addr_region_router_tb.sv
module addr_region_router_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [11:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] req_addr = '0;
   logic [1:0]  route_tgt;
   logic        attr_ovr_vld;
   logic [2:0]  attr_ovr_val;
   logic        no_l2_alloc;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   addr_region_router u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .req_addr(req_addr), .route_tgt(route_tgt),
      .attr_ovr_vld(attr_ovr_vld), .attr_ovr_val(attr_ovr_val),
      .no_l2_alloc(no_l2_alloc)
   );

   function automatic logic [31:0] mk_mask(logic [15:0] m, logic [1:0] dest,
                                           logic drop, logic oen, logic [2:0] oval);
      return {m, 8'h00, oval, oen, 1'b0, drop, dest};
   endfunction

   task automatic chk(string tag, logic [1:0] et, logic ev, logic [2:0] eo, logic ed);
      total++;
      if (route_tgt !== et || attr_ovr_vld !== ev || attr_ovr_val !== eo || no_l2_alloc !== ed) begin
         bad++;
         $display("FAIL %s addr=%h got tgt=%0d vld=%0d val=%0d drop=%0d exp tgt=%0d vld=%0d val=%0d drop=%0d",
                  tag, req_addr, route_tgt, attr_ovr_vld, attr_ovr_val, no_l2_alloc, et, ev, eo, ed);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic at(logic [31:0] a);
      @(negedge clk);
      req_addr = a;
      #1;
   endtask

   task automatic t_reset();
      at(32'h1234_5678);
      chk("R1 reset", 2'd0, 1'b0, 3'd0, 1'b0);
   endtask

   task automatic t_default();
      at(32'h2000_0000);
      // R3: strobe high before the capturing edge, old result still seen
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'h008; wr_data = 32'd3;
      #1;
      chk("R3 before edge", 2'd0, 1'b0, 3'd0, 1'b0);
      @(negedge clk);
      wr_en = 1'b0;
      #1;
      chk("R3 after edge", 2'd3, 1'b0, 3'd0, 1'b0);
      wr(12'h008, 32'd1);
      #1;
      chk("R8 reserved default", 2'd1, 1'b0, 3'd0, 1'b0);
      wr(12'h008, 32'hFFFF_FFF2);
      #1;
      chk("R8 default io0", 2'd2, 1'b0, 3'd0, 1'b0);
   endtask

   task automatic t_window();
      wr(12'h090, 32'h1000_0000);
      wr(12'h098, mk_mask(16'hF000, 2'd3, 1'b0, 1'b0, 3'd0));
      at(32'h1234_5678);
      chk("R4 window hit", 2'd3, 1'b0, 3'd0, 1'b0);
      at(32'h2000_0000);
      chk("R8 miss to default", 2'd2, 1'b0, 3'd0, 1'b0);
      at(32'h1000_FFFF);
      chk("R11 low bits ignored", 2'd3, 1'b0, 3'd0, 1'b0);
      wr(12'h090, 32'h1F00_0000);
      at(32'h1000_0000);
      chk("R11 unmasked base bits", 2'd3, 1'b0, 3'd0, 1'b0);
      wr(12'h098, mk_mask(16'hF000, 2'd1, 1'b0, 1'b0, 3'd0));
      #1;
      chk("R6 memory maps to 0", 2'd0, 1'b0, 3'd0, 1'b0);
      wr(12'h098, mk_mask(16'hF000, 2'd0, 1'b1, 1'b1, 3'd7));
      #1;
      chk("R5 disabled window", 2'd2, 1'b0, 3'd0, 1'b0);
   endtask

   task automatic t_priority();
      wr(12'h0a0, 32'h4000_0000);
      wr(12'h0a8, mk_mask(16'hC000, 2'd3, 1'b0, 1'b1, 3'd6));
      wr(12'h0b0, 32'h4000_0000);
      wr(12'h0b8, mk_mask(16'hF000, 2'd1, 1'b1, 1'b0, 3'd0));
      at(32'h4100_0000);
      chk("R7 lower index wins", 2'd3, 1'b1, 3'd6, 1'b0);
      wr(12'h0a8, mk_mask(16'hC000, 2'd0, 1'b0, 1'b1, 3'd6));
      #1;
      chk("R10 drop flag", 2'd0, 1'b0, 3'd0, 1'b1);
      wr(12'h0c0, 32'hABCD_0000);
      wr(12'h0c8, mk_mask(16'h0000, 2'd2, 1'b0, 1'b1, 3'd5));
      at(32'h9000_0000);
      chk("R4 zero mask covers all", 2'd2, 1'b1, 3'd5, 1'b0);
      at(32'h4100_0000);
      chk("R7 window2 over window3", 2'd0, 1'b0, 3'd0, 1'b1);
   endtask

   task automatic t_override();
      wr(12'h0c8, mk_mask(16'h0000, 2'd2, 1'b0, 1'b0, 3'd5));
      at(32'h9000_0000);
      chk("R9 override off zero value", 2'd2, 1'b0, 3'd0, 1'b0);
   endtask

   task automatic t_ignored();
      wr(12'h0a4, 32'hFFFF_FFFF);
      wr(12'h0cc, 32'hFFFF_FFFF);
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 12'h0c8; wr_data = mk_mask(16'h0000, 2'd3, 1'b1, 1'b1, 3'd7);
      @(negedge clk);
      wr_addr = 12'h008; wr_data = 32'd3;
      @(negedge clk);
      at(32'h9000_0000);
      chk("R2 stray writes ignored w3", 2'd2, 1'b0, 3'd0, 1'b0);
      at(32'h4100_0000);
      chk("R2 stray writes ignored w2", 2'd0, 1'b0, 3'd0, 1'b1);
      wr(12'h0c8, 32'd0);
      at(32'h7000_0000);
      chk("R2 default kept", 2'd2, 1'b0, 3'd0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_default();
      t_window();
      t_priority();
      t_override();
      t_ignored();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule